// File: doc/BRIEF.md
# Matrix Keypad Change-Event Encoder

This block scans an 8x8 switch matrix and turns every accepted change of a key (press or release) into one 8-bit event word. Columns are driven active-low one at a time; rows idle high through external pull-ups, so a closed switch pulls its row low while its column is driven. The host never sees the full 64-bit key state. It waits for the interrupt line, reads the oldest event from the head of an 8-entry queue and pops it.

A change is accepted only when two consecutive full scans agree on it. Readings that cannot be trusted are held back: when four keys forming the corners of a rectangle all read as pressed, one of them may be a phantom, so none of the four is allowed to change state until the pattern breaks. Every other key is reported on its own, so any number of unambiguous keys may be held together. With nothing held, the block parks in a sleep state that drives all columns low at once and does no scanning until a row falls.

Top module: `keymatrix_event_encoder`

## Requirements
- R1: While scanning, exactly one column output is low at a time; columns are visited in ascending order 0 to 7, each held low for SETTLE clock cycles (default 4), and a key at row r, column c reads pressed when row r is low while column c is driven.
- R2: An event word is {press, 1'b0, row[2:0], col[2:0]}: bit 7 is 1 for a press and 0 for a release, bit 6 is always 0, bits 5:3 give the row and bits 2:0 the column.
- R3: Only state changes produce events; a key held down produces no further events after its press event.
- R4: A key change is accepted only when two consecutive full scans both show it; a pulse shorter than one scan produces no event.
- R5: When four keys at the corners of a rectangle all read as pressed, none of those four keys changes its reported state and no event is produced for them; once the pattern breaks, the remaining keys are reported normally.
- R6: Several unambiguous changes accepted in the same scan are each reported, in ascending order of row*8+column.
- R7: In sleep all eight column outputs are low and stay low while all rows read high; any row going low starts a scan at column 0.
- R8: After the last release event is queued, the block returns to sleep only after one further full scan in which no key is seen, so at least 8*SETTLE cycles pass between that event and sleep.
- R9: Events are held in an 8-entry first-in first-out queue; evt_code shows the oldest entry and a pop removes it.
- R10: irq is high exactly while the queue holds at least one event.
- R11: An event arriving while the queue is full is dropped and the overflow output is set and stays set until reset.
- R12: A low rst_n at a clock edge clears all key state, empties the queue, lowers irq and overflow, and enters sleep (all columns low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_n | output | 8 | Column drives, active low |
| row_n | input | 8 | Row sense lines, low when a key on the driven column is closed |
| pop | input | 1 | Remove the oldest event from the queue |
| evt_code | output | 8 | Oldest queued event word, valid while irq is high |
| irq | output | 1 | Events are waiting |
| overflow | output | 1 | Sticky flag: an event was dropped because the queue was full |

## Verification
The assertions assume the row lines are a pure function of which columns are driven and which switches are closed, so a row can only read low through a closed switch path, and that pop is only meaningful while irq is high. The bench models the matrix itself, including the phantom path through three closed switches, and derives row_n combinationally from the column drives. Random key patterns are restricted to at most four closed keys with no three on the corners of a rectangle, and at most three changes between drains, so the queue cannot overflow and scans that straddle a change cannot yield a value that is not final; phantom patterns and overflow are driven only in directed sequences that change a single key at a time.

// File: rtl/keymatrix_event_encoder.sv
module keymatrix_event_encoder #(
  parameter int SETTLE     = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] col_n,
  input  logic [7:0] row_n,
  input  logic       pop,
  output logic [7:0] evt_code,
  output logic       irq,
  output logic       overflow
);
  localparam int TW = $clog2(SETTLE);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam logic [TW-1:0] TICK_LAST = TW'(SETTLE - 1);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(FIFO_DEPTH);

  typedef enum logic [1:0] {SLEEP, SCAN, EMIT} phase_t;

  phase_t        phase;
  logic [7:0]    row_q;
  logic [2:0]    col;
  logic [TW-1:0] tick;
  logic [5:0]    idx;
  logic [63:0]   cur, prev, stable, ambig, pend;
  logic          any_evt;
  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, count;
  logic          push, full, do_pop, quiet;

  always_comb begin
    for (int k = 0; k < 64; k++) begin
      ambig[k] = 1'b0;
      for (int r2 = 0; r2 < 8; r2++)
        for (int c2 = 0; c2 < 8; c2++)
          if (r2 != k / 8 && c2 != k % 8 && cur[(k / 8) * 8 + c2] &&
              cur[r2 * 8 + k % 8] && cur[r2 * 8 + c2])
            ambig[k] = 1'b1;
      ambig[k] = ambig[k] & cur[k];
    end
  end

  assign pend     = ~(cur ^ prev) & (cur ^ stable) & ~ambig;
  assign push     = (phase == EMIT) && pend[idx];
  assign count    = wr_ptr - rd_ptr;
  assign full     = (count == DEPTH_W);
  assign do_pop   = pop && (count != '0);
  assign quiet    = (cur == '0) && (stable == '0) && !any_evt && !push;
  assign irq      = (count != '0);
  assign evt_code = mem[rd_ptr[AW-1:0]];
  assign col_n    = (phase == SLEEP) ? 8'h00 :
                    (phase == SCAN)  ? ~(8'h01 << col) : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= SLEEP;
      row_q    <= 8'hFF;
      col      <= '0;
      tick     <= '0;
      idx      <= '0;
      cur      <= '0;
      prev     <= '0;
      stable   <= '0;
      any_evt  <= 1'b0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      row_q <= row_n;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (push) begin
        stable[idx] <= cur[idx];
        any_evt     <= 1'b1;
        if (full) overflow <= 1'b1;
        else      wr_ptr   <= wr_ptr + 1'b1;
      end
      case (phase)
        SLEEP: if (row_q != 8'hFF) begin
          phase <= SCAN;
          col   <= '0;
          tick  <= '0;
        end
        SCAN: if (tick == TICK_LAST) begin
          tick <= '0;
          for (int r = 0; r < 8; r++) cur[r * 8 + int'(col)] <= ~row_q[r];
          if (col == 3'd7) begin
            phase   <= EMIT;
            idx     <= '0;
            any_evt <= 1'b0;
          end
          col <= col + 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
        EMIT: begin
          idx <= idx + 1'b1;
          if (idx == 6'd63) begin
            prev  <= cur;
            phase <= quiet ? SLEEP : SCAN;
            tick  <= '0;
          end
        end
        default: phase <= SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push && !full) mem[wr_ptr[AW-1:0]] <= {cur[idx], 1'b0, idx};

  assert_col_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    col_n != 8'h00 |-> $onehot0(~col_n));
  assert_code_bit6_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !evt_code[6]);
  assert_state_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != EMIT |=> $stable(stable));
  assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_n == 8'h00 && row_q == 8'hFF) |=> col_n == 8'h00);
  assert_queue_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_W);
  assert_irq_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (AW+1)'(1) && do_pop && !push) |=> !irq);
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_full_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> overflow);
endmodule

// File: tb/keymatrix_event_encoder_test.sv
module keymatrix_event_encoder_test;
  localparam int SETTLE = 4;
  localparam int WAITC  = 800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pop, irq, overflow;
  logic [7:0] col_n, row_n, evt_code;
  logic [63:0] keys, app, stable_m;
  int ncheck = 0, nerr = 0;
  bit done = 0;

  keymatrix_event_encoder #(.SETTLE(SETTLE), .FIFO_DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .row_n(row_n), .pop(pop),
    .evt_code(evt_code), .irq(irq), .overflow(overflow));

  function automatic logic [63:0] apparent(input logic [63:0] k);
    logic [63:0] a = k;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        for (int r2 = 0; r2 < 8; r2++)
          for (int c2 = 0; c2 < 8; c2++)
            if (k[r*8+c2] && k[r2*8+c2] && k[r2*8+c]) a[r*8+c] = 1'b1;
    return a;
  endfunction

  function automatic logic [63:0] unsure(input logic [63:0] a);
    logic [63:0] u = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        for (int r2 = 0; r2 < 8; r2++)
          for (int c2 = 0; c2 < 8; c2++)
            if (r2 != r && c2 != c && a[r*8+c] && a[r*8+c2] && a[r2*8+c] && a[r2*8+c2])
              u[r*8+c] = 1'b1;
    return u;
  endfunction

  assign app = apparent(keys);
  always_comb
    for (int r = 0; r < 8; r++) row_n[r] = ~|(app[r*8 +: 8] & ~col_n);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    ncheck++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pop = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    stable_m = '0;
    @(negedge clk);
  endtask

  task automatic predict(output logic [255:0] expset);
    logic [63:0] a = apparent(keys);
    logic [63:0] u = unsure(a);
    expset = '0;
    for (int k = 0; k < 64; k++)
      if (!u[k] && a[k] != stable_m[k]) begin
        expset[{a[k], 1'b0, 6'(k)}] = 1'b1;
        stable_m[k] = a[k];
      end
  endtask

  task automatic drain(input logic [255:0] expset_in, input string req);
    logic [255:0] expset = expset_in;
    int guard = 0;
    while (irq && guard < 40) begin
      check(expset[evt_code] == 1'b1, req, evt_code, 1);
      expset[evt_code] = 1'b0;
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      guard++;
    end
    check($countones(expset) == 0, req, $countones(expset), 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      ncheck++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, ncheck);
      $finish;
    end
  end

  initial begin
    logic [255:0] es;
    int n, guard, pressed;
    logic [63:0] trial;
    logic [7:0] want [8];
    keys = '0; rst_n = 1'b0; pop = 1'b0; stable_m = '0;
    do_reset();

    // R12: reset state
    check(col_n == 8'h00, "R12 cols", col_n, 0);
    check(irq == 1'b0, "R12 irq", irq, 0);
    check(overflow == 1'b0, "R12 overflow", overflow, 0);

    // R7: idle sleep, no scanning
    n = 0;
    repeat (300) begin @(negedge clk); if (col_n != 8'h00) n++; end
    check(n == 0, "R7 sleep idle", n, 0);

    // R1: column sequencing after wake
    keys[29] = 1'b1;
    guard = 0;
    while (col_n != 8'hFE && guard < 50) begin @(negedge clk); guard++; end
    check(col_n == 8'hFE, "R7 wake to col0", col_n, 8'hFE);
    for (int c = 0; c < 8; c++) begin
      n = 0;
      while (col_n == ~(8'h01 << c) && n < 20) begin n++; @(negedge clk); end
      check(n == SETTLE, "R1 column hold", n, SETTLE);
    end

    // R2: press code format, row 3 col 5
    wait_cycles(WAITC);
    check(irq == 1'b1, "R10 irq with event", irq, 1);
    check(evt_code == 8'h9D, "R2 press code", evt_code, 8'h9D);
    predict(es);
    drain(es, "R2");
    check(irq == 1'b0, "R10 irq empty", irq, 0);

    // R4: short pulse ignored; R3: held key silent
    keys[9] = 1'b1; wait_cycles(3); keys[9] = 1'b0;
    wait_cycles(WAITC);
    check(irq == 1'b0, "R4 glitch ignored", irq, 0);
    check(irq == 1'b0, "R3 held key silent", irq, 0);

    // R8: one empty scan before sleep
    keys[29] = 1'b0;
    guard = 0;
    while (!irq && guard < 1000) begin @(negedge clk); guard++; end
    check(evt_code == 8'h1D, "R2 release code", evt_code, 8'h1D);
    n = 0;
    while (col_n != 8'h00 && n < 1000) begin @(negedge clk); n++; end
    check(n >= 8*SETTLE && n <= 8*SETTLE + 140, "R8 sleep delay", n, 8*SETTLE);
    predict(es);
    drain(es, "R8");

    // R5: phantom corner
    keys[0] = 1'b1; keys[1] = 1'b1;
    wait_cycles(WAITC); predict(es); drain(es, "R5 setup");
    keys[8] = 1'b1;
    wait_cycles(WAITC);
    check(irq == 1'b0, "R5 ambiguous silent", irq, 0);
    predict(es); drain(es, "R5");
    keys[1] = 1'b0;
    wait_cycles(WAITC);
    predict(es);
    check(es[8'h01] && es[8'h88], "R5 resolved", $countones(es), 2);
    drain(es, "R5 resolve");
    keys = '0;
    wait_cycles(WAITC); predict(es); drain(es, "R5 clear");
    check(col_n == 8'h00, "R8 back to sleep", col_n, 0);

    // R6 / R3: constrained random patterns
    void'($urandom(32'h5EED_1234));
    for (int step = 0; step < 100; step++) begin
      trial = keys;
      for (int t = 0; t < 20; t++) begin
        trial = keys;
        for (int j = 0; j <= int'($urandom % 3); j++) trial[$urandom % 64] ^= 1'b1;
        pressed = $countones(trial);
        if (pressed <= 4 && unsure(apparent(trial)) == '0) break;
        trial = keys;
      end
      keys = trial;
      wait_cycles(WAITC);
      predict(es);
      drain(es, "R6");
    end
    check(overflow == 1'b0, "R11 no false overflow", overflow, 0);

    // R11 / R9: overflow, oldest first
    keys = '0;
    wait_cycles(WAITC); predict(es); drain(es, "R6 clear");
    do_reset();
    for (int c = 0; c < 4; c++) keys[c] = 1'b1;
    for (int r = 1; r < 8; r++) keys[r*8+4] = 1'b1;
    wait_cycles(WAITC);
    check(overflow == 1'b1, "R11 overflow set", overflow, 1);
    want = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h8C, 8'h94, 8'h9C, 8'hA4};
    for (int i = 0; i < 8; i++) begin
      check(irq == 1'b1, "R10 irq while queued", irq, 1);
      check(evt_code == want[i], "R9 queue order", evt_code, want[i]);
      pop = 1'b1; @(negedge clk); pop = 1'b0;
    end
    check(irq == 1'b0, "R11 dropped events", irq, 0);
    wait_cycles(WAITC);
    check(irq == 1'b0, "R11 no late events", irq, 0);
    check(overflow == 1'b1, "R11 sticky", overflow, 1);
    keys = '0;
    wait_cycles(WAITC);
    check(irq == 1'b1, "R6 releases queued", irq, 1);

    // R12: reset while active
    do_reset();
    check(irq == 1'b0, "R12 irq cleared", irq, 0);
    check(overflow == 1'b0, "R12 overflow cleared", overflow, 0);
    check(col_n == 8'h00, "R12 sleep", col_n, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, ncheck);
    $finish;
  end
endmodule